// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block is a 64-entry address translation cache kept entirely by software. Every entry has two 32-bit halves. The tag half holds a virtual page number, a page-size code and a valid flag. The data half holds a real page number, execute and write permissions, a 4-bit zone field and four memory attributes. Software fills and inspects entries one half at a time through an indexed access port. A search port tells software which slot, if any, covers a given virtual address.

A translation port takes an effective address and returns the real address, the zone and attribute bits, and two fault flags, one for writes and one for fetches. Each entry has its own page size, from 1 KB to 16 MB in steps of four. The compare mask and the split between page number and offset therefore change from entry to entry. Software can drop the one entry that covers an address, or clear the whole table in a single cycle.

Top module: `vpt_tlb`

## Requirements
- R1: Access half-select 0 addresses the tag word, laid out as page number in bits 31:10, size code in bits 9:7 and valid flag in bit 6. Tag bits 5:0 are not stored and read back as zero. Read data appears on `acc_rdata` one cycle after the read request.
- R2: Half-select 1 addresses the data word, stored and read back as all 32 bits: real page number in bits 31:10, execute-allowed in bit 9, write-allowed in bit 8, zone in bits 7:4, attributes in bits 3:0.
- R3: A valid entry with size code k (0 = 1 KB up to 7 = 16 MB) matches an address when address bits 31 down to 10+2k equal the same bits of the entry's page number. Invalid entries never match.
- R4: On a hit, the real address takes bits 31 down to 10+2k from the real page number and the bits below from the effective address. Zone and attributes come from data bits 7:4 and 3:0. On a miss, the real address, zone and attributes are zero.
- R5: When several entries match, the lowest index wins. The search port returns a hit flag and that 6-bit index. On a miss it returns hit 0 and index 0.
- R6: Search and translation results are registered and valid exactly one cycle after the request. An entry written in cycle N is seen by a request made in cycle N+1.
- R7: A translation with write asserted that hits an entry whose write-allowed bit is clear raises `xl_wr_fault`. No fault is raised on a miss.
- R8: A translation with fetch asserted that hits an entry whose execute bit is clear raises `xl_ex_fault`.
- R9: Reset leaves every entry invalid with all fields zero. `inv_all` clears every valid flag in one cycle and takes precedence over a write in the same cycle.
- R10: `inv_one` clears the valid flag of only the lowest-index entry that matches `inv_va`. If no entry matches, the table is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access port request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_half | input | 1 | 0 = tag word, 1 = data word |
| acc_idx | input | 6 | Entry index |
| acc_wdata | input | 32 | Write word |
| acc_rdata | output | 32 | Read word, registered |
| srch_req | input | 1 | Search request |
| srch_va | input | 32 | Search address |
| srch_hit | output | 1 | Search found an entry |
| srch_idx | output | 6 | Index of lowest matching entry |
| xl_req | input | 1 | Translation request |
| xl_ea | input | 32 | Effective address |
| xl_wr | input | 1 | Access is a write |
| xl_fetch | input | 1 | Access is an instruction fetch |
| xl_valid | output | 1 | Translation result valid |
| xl_hit | output | 1 | Translation hit |
| xl_ra | output | 32 | Real address |
| xl_zone | output | 4 | Zone field of the hit entry |
| xl_attr | output | 4 | Attribute bits of the hit entry |
| xl_wr_fault | output | 1 | Write to a non-writable page |
| xl_ex_fault | output | 1 | Fetch from a non-executable page |
| inv_one | input | 1 | Invalidate the entry matching inv_va |
| inv_va | input | 32 | Address for single invalidation |
| inv_all | input | 1 | Invalidate every entry |

## Verification
Overlapping entries of different sizes show whether the priority and the masks are right. A wrong size mask in one entry gives either a false hit or a miss one cycle after the request. It also shows up as real-address bits taken from the wrong source at the page boundary. A stale valid flag, left by a faulty invalidate or write, appears on the next search of that address, which returns the wrong index or hits when it should miss. Corrupted stored fields show up through indexed read-back one cycle after the read.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int ADDR_W = 32;
  localparam int PG_LSB = 10;
  localparam int PN_W   = ADDR_W - PG_LSB;
  localparam int SZ_W   = 3;

  typedef struct packed {
    logic [PN_W-1:0] pn;
    logic [SZ_W-1:0] sz;
    logic            vld;
  } tag_t;

  typedef struct packed {
    logic [PN_W-1:0] rpn;
    logic            ex;
    logic            wr;
    logic [3:0]      zone;
    logic [3:0]      attr;
  } dat_t;

  // Mask of the address bits that take part in the compare for size code sz.
  function automatic logic [ADDR_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    int sh;
    sh = PG_LSB + 2 * int'(sz);
    return {ADDR_W{1'b1}} << sh;
  endfunction

  function automatic logic [ADDR_W-1:0] tag_word(input tag_t t);
    return {t.pn, t.sz, t.vld, {(PG_LSB-SZ_W-1){1'b0}}};
  endfunction

  function automatic logic entry_hit(input tag_t t, input logic [ADDR_W-1:0] a);
    return t.vld && ((({t.pn, {PG_LSB{1'b0}}} ^ a) & page_mask(t.sz)) == '0);
  endfunction

  function automatic logic [ADDR_W-1:0] real_addr(input dat_t d,
                                                  input logic [SZ_W-1:0] sz,
                                                  input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = page_mask(sz);
    return ({d.rpn, {PG_LSB{1'b0}}} & m) | (a & ~m);
  endfunction
endpackage

// File: rtl/vtlb_store.sv
module vtlb_store
  import vtlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_half,
  input  logic [IW-1:0]     wr_idx,
  input  logic [ADDR_W-1:0] wr_word,
  input  logic              inv_all,
  input  logic              inv_one_en,
  input  logic [IW-1:0]     inv_one_idx,
  output tag_t              tags [N],
  output dat_t              dats [N]
);
  logic [N-1:0] vld_vec;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic sel_w, sel_i;
    assign sel_w = wr_en && (wr_idx == IW'(i));
    assign sel_i = inv_one_en && (inv_one_idx == IW'(i));
    assign vld_vec[i] = tags[i].vld;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tags[i] <= '0;
        dats[i] <= '0;
      end else if (inv_all) begin
        tags[i].vld <= 1'b0;
      end else begin
        if (sel_i) tags[i].vld <= 1'b0;
        if (sel_w && !wr_half) begin
          tags[i].pn  <= wr_word[ADDR_W-1:PG_LSB];
          tags[i].sz  <= wr_word[PG_LSB-1:PG_LSB-SZ_W];
          tags[i].vld <= wr_word[PG_LSB-SZ_W-1];
        end
        if (sel_w && wr_half) dats[i] <= dat_t'(wr_word);
      end
    end
  end

  p_inv_all_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_vec == '0));
endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int N = 64
) (
  input  tag_t              tags [N],
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = entry_hit(tags[i], addr);
  end
endmodule

// File: rtl/vtlb_prio.sv
module vtlb_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = i[IW-1:0];
      end
    end
  end

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (vec[idx] && ((vec & ~({N{1'b1}} << idx)) == '0)));
  p_none_found_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == '0) |-> (!found && idx == '0));
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vtlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic              acc_half,
  input  logic [IW-1:0]     acc_idx,
  input  logic [ADDR_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] acc_rdata,
  input  logic              srch_req,
  input  logic [ADDR_W-1:0] srch_va,
  output logic              srch_hit,
  output logic [IW-1:0]     srch_idx,
  input  logic              xl_req,
  input  logic [ADDR_W-1:0] xl_ea,
  input  logic              xl_wr,
  input  logic              xl_fetch,
  output logic              xl_valid,
  output logic              xl_hit,
  output logic [ADDR_W-1:0] xl_ra,
  output logic [3:0]        xl_zone,
  output logic [3:0]        xl_attr,
  output logic              xl_wr_fault,
  output logic              xl_ex_fault,
  input  logic              inv_one,
  input  logic [ADDR_W-1:0] inv_va,
  input  logic              inv_all
);
  localparam int NLOOK = 3;  // 0 search, 1 translate, 2 invalidate
  localparam int L_SRCH = 0;
  localparam int L_XL   = 1;
  localparam int L_INV  = 2;

  tag_t tags [N];
  dat_t dats [N];

  logic [ADDR_W-1:0] look_addr  [NLOOK];
  logic [N-1:0]      look_vec   [NLOOK];
  logic              look_found [NLOOK];
  logic [IW-1:0]     look_idx   [NLOOK];

  // Named internal events
  logic srch_hit_c, xl_hit_c, inv_hit_c, inv_fire, wr_fire, rd_fire;

  assign look_addr[L_SRCH] = srch_va;
  assign look_addr[L_XL]   = xl_ea;
  assign look_addr[L_INV]  = inv_va;

  for (genvar g = 0; g < NLOOK; g++) begin : g_look
    vtlb_match #(.N(N)) u_match (
      .tags(tags), .addr(look_addr[g]), .hit_vec(look_vec[g]));
    vtlb_prio #(.N(N), .IW(IW)) u_prio (
      .clk(clk), .rst_n(rst_n), .vec(look_vec[g]),
      .found(look_found[g]), .idx(look_idx[g]));
  end

  assign srch_hit_c = look_found[L_SRCH];
  assign xl_hit_c   = look_found[L_XL];
  assign inv_hit_c  = look_found[L_INV];
  assign inv_fire   = inv_one && inv_hit_c;
  assign wr_fire    = acc_en && acc_we;
  assign rd_fire    = acc_en && !acc_we;

  vtlb_store #(.N(N), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_half(acc_half), .wr_idx(acc_idx), .wr_word(acc_wdata),
    .inv_all(inv_all), .inv_one_en(inv_fire), .inv_one_idx(look_idx[L_INV]),
    .tags(tags), .dats(dats));

  tag_t xl_tag;
  dat_t xl_dat;
  assign xl_tag = tags[look_idx[L_XL]];
  assign xl_dat = dats[look_idx[L_XL]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rdata <= '0;
      srch_hit  <= 1'b0;
      srch_idx  <= '0;
      xl_valid  <= 1'b0;
      xl_hit    <= 1'b0;
      xl_ra     <= '0;
      xl_zone   <= '0;
      xl_attr   <= '0;
      xl_wr_fault <= 1'b0;
      xl_ex_fault <= 1'b0;
    end else begin
      if (rd_fire)
        acc_rdata <= acc_half ? ADDR_W'(dats[acc_idx]) : tag_word(tags[acc_idx]);
      if (srch_req) begin
        srch_hit <= srch_hit_c;
        srch_idx <= look_idx[L_SRCH];
      end
      xl_valid <= xl_req;
      if (xl_req) begin
        xl_hit      <= xl_hit_c;
        xl_ra       <= xl_hit_c ? real_addr(xl_dat, xl_tag.sz, xl_ea) : '0;
        xl_zone     <= xl_hit_c ? xl_dat.zone : '0;
        xl_attr     <= xl_hit_c ? xl_dat.attr : '0;
        xl_wr_fault <= xl_hit_c && xl_wr && !xl_dat.wr;
        xl_ex_fault <= xl_hit_c && xl_fetch && !xl_dat.ex;
      end
    end
  end

  p_rsp_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_valid);
  p_fault_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_wr_fault || xl_ex_fault) |-> xl_hit);
  p_wr_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !xl_wr) |=> !xl_wr_fault);
  p_ex_fault_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !xl_fetch) |=> !xl_ex_fault);
  p_miss_zero_ra_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !xl_hit) |-> (xl_ra == '0 && xl_zone == '0 && xl_attr == '0));
  p_inv_hits_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_fire && !inv_all && !wr_fire) |=> !tags[$past(look_idx[L_INV])].vld);
endmodule

// File: tb/vpt_tlb_tb_top.sv
module vpt_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 0, acc_we = 0, acc_half = 0;
  logic [5:0]  acc_idx = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic        srch_req = 0, srch_hit;
  logic [31:0] srch_va = '0;
  logic [5:0]  srch_idx;
  logic        xl_req = 0, xl_wr = 0, xl_fetch = 0;
  logic [31:0] xl_ea = '0, xl_ra;
  logic        xl_valid, xl_hit, xl_wr_fault, xl_ex_fault;
  logic [3:0]  xl_zone, xl_attr;
  logic        inv_one = 0, inv_all = 0;
  logic [31:0] inv_va = '0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  vpt_tlb dut_i (.*);

  typedef struct packed {
    logic [31:0] ea; logic wr; logic fe;
    logic hit; logic [31:0] ra; logic wf; logic xf;
    logic [3:0] zone; logic [3:0] attr;
  } xv_t;

  localparam xv_t XV [8] = '{
    '{32'h1000_0123, 1'b0, 1'b0, 1'b1, 32'h8000_0123, 1'b0, 1'b0, 4'h3, 4'hA},
    '{32'h1000_0FFF, 1'b1, 1'b0, 1'b1, 32'h8000_0FFF, 1'b1, 1'b0, 4'h3, 4'hA},
    '{32'h1000_1000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 4'h0, 4'h0},
    '{32'h20AB_CDEF, 1'b1, 1'b1, 1'b1, 32'h40AB_CDEF, 1'b0, 1'b1, 4'h5, 4'h1},
    '{32'h2040_01FF, 1'b1, 1'b1, 1'b1, 32'h0ABC_D1FF, 1'b0, 1'b0, 4'h0, 4'h0},
    '{32'h2040_0400, 1'b0, 1'b1, 1'b1, 32'h4040_0400, 1'b0, 1'b1, 4'h5, 4'h1},
    '{32'h3000_0000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 4'h0, 4'h0},
    '{32'h1000_0000, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 4'h3, 4'hA}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic half, input logic [5:0] idx, input logic [31:0] w);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_half = half; acc_idx = idx; acc_wdata = w;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic half, input logic [5:0] idx,
                        input logic [31:0] exp);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_half = half; acc_idx = idx;
    @(negedge clk);
    acc_en = 0;
    chk(tag, acc_rdata, exp);
  endtask

  task automatic srch_chk(input string tag, input logic [31:0] va,
                          input logic hit, input logic [5:0] idx);
    @(negedge clk);
    srch_req = 1; srch_va = va;
    @(negedge clk);
    srch_req = 0;
    chk({tag, " hit"}, {31'b0, srch_hit}, {31'b0, hit});
    chk({tag, " idx"}, {26'b0, srch_idx}, {26'b0, idx});
  endtask

  task automatic xl_chk(input string tag, input xv_t v);
    @(negedge clk);
    xl_req = 1; xl_ea = v.ea; xl_wr = v.wr; xl_fetch = v.fe;
    @(negedge clk);
    xl_req = 0;
    chk({tag, " valid"}, {31'b0, xl_valid}, 32'd1);
    chk({tag, " hit"}, {31'b0, xl_hit}, {31'b0, v.hit});
    chk({tag, " ra"}, xl_ra, v.ra);
    chk({tag, " faults"}, {30'b0, xl_wr_fault, xl_ex_fault}, {30'b0, v.wf, v.xf});
    chk({tag, " zone/attr"}, {24'b0, xl_zone, xl_attr}, {24'b0, v.zone, v.attr});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    chk("R9 reset xl_valid", {31'b0, xl_valid}, 32'd0);
    chk("R9 reset srch_hit", {31'b0, srch_hit}, 32'd0);
    rd_chk("R9 reset tag idx5", 1'b0, 6'd5, 32'h0);
    srch_chk("R9 reset search", 32'h0000_0000, 1'b0, 6'd0);

    // Table set-up
    wr_word(1'b1, 6'd5,  32'h8000_023A);
    wr_word(1'b0, 6'd5,  32'h1000_00FF);  // low junk bits dropped (R1)
    wr_word(1'b1, 6'd9,  32'h4000_0151);
    wr_word(1'b0, 6'd9,  32'h2000_03C0);  // 16 MB page
    wr_word(1'b1, 6'd2,  32'h0ABC_D300);
    wr_word(1'b0, 6'd2,  32'h2040_0040);  // 1 KB page inside the 16 MB one
    wr_word(1'b1, 6'd63, 32'h1234_5300);
    wr_word(1'b0, 6'd63, 32'h3000_0000);  // not valid

    rd_chk("R1 tag readback idx5", 1'b0, 6'd5, 32'h1000_00C0);
    rd_chk("R1 tag readback idx9", 1'b0, 6'd9, 32'h2000_03C0);
    rd_chk("R2 data readback idx9", 1'b1, 6'd9, 32'h4000_0151);
    rd_chk("R2 data readback idx5", 1'b1, 6'd5, 32'h8000_023A);

    // R3 R4 R7 R8 R5 translation vectors
    for (int k = 0; k < 8; k++) xl_chk($sformatf("R3/R4/R7/R8 vec%0d", k), XV[k]);

    // R5 search priority and miss
    srch_chk("R5 overlap lowest idx", 32'h2040_01FF, 1'b1, 6'd2);
    srch_chk("R5 big page", 32'h20FF_FFFF, 1'b1, 6'd9);
    srch_chk("R5 4K page", 32'h1000_0ABC, 1'b1, 6'd5);
    srch_chk("R5 miss", 32'h5000_0000, 1'b0, 6'd0);

    // R6 write then lookup in the next cycle
    wr_word(1'b1, 6'd20, 32'h7000_0000);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_half = 0; acc_idx = 6'd20; acc_wdata = 32'h6000_0040;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
    xl_req = 1; xl_ea = 32'h6000_0004; xl_wr = 0; xl_fetch = 0;
    @(negedge clk);
    xl_req = 0;
    chk("R6 next-cycle hit", {31'b0, xl_hit}, 32'd1);
    chk("R6 next-cycle ra", xl_ra, 32'h7000_0004);
    @(negedge clk);
    chk("R6 valid drops", {31'b0, xl_valid}, 32'd0);

    // R10 single invalidation hits the lowest match only
    @(negedge clk);
    inv_one = 1; inv_va = 32'h2040_0000;
    @(negedge clk);
    inv_one = 0;
    xl_chk("R10 after inv_one", '{32'h2040_01FF, 1'b0, 1'b0, 1'b1, 32'h4040_01FF,
                                  1'b0, 1'b0, 4'h5, 4'h1});
    rd_chk("R10 idx2 tag cleared", 1'b0, 6'd2, 32'h2040_0000);
    @(negedge clk);
    inv_one = 1; inv_va = 32'h5500_0000;
    @(negedge clk);
    inv_one = 0;
    srch_chk("R10 no-match keeps idx9", 32'h20FF_FFFF, 1'b1, 6'd9);
    srch_chk("R10 no-match keeps idx5", 32'h1000_0000, 1'b1, 6'd5);

    // R9 invalidate-all beats a same-cycle write
    @(negedge clk);
    inv_all = 1; acc_en = 1; acc_we = 1; acc_half = 0; acc_idx = 6'd30;
    acc_wdata = 32'h7700_0040;
    @(negedge clk);
    inv_all = 0; acc_en = 0; acc_we = 0;
    srch_chk("R9 inv_all 4K", 32'h1000_0000, 1'b0, 6'd0);
    srch_chk("R9 inv_all write lost", 32'h7700_0000, 1'b0, 6'd0);
    xl_chk("R9 inv_all xlate", '{32'h20AB_CDEF, 1'b0, 1'b0, 1'b0, 32'h0,
                                 1'b0, 1'b0, 4'h0, 4'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule